// File: doc/BRIEF.md
# Copy-Table Section Loader

This engine carries out a second-stage program load without processor help. After a start pulse it reads a packed copy table from a byte-addressable source memory, beginning at a given base address. It then copies every section the table describes into a destination RAM, one byte per write. When it meets the terminating entry, it presents the execution entry point it read at the beginning of the table.

The table opens with a 32-bit entry-point word. Section records follow, each made of a byte count, a destination address and then the payload bytes. After each payload the source pointer is padded forward to the next 4-byte boundary. A record whose count is zero ends the table.

The source port has a read latency of one cycle. A word read returns four bytes in little-endian order. A byte read returns one byte in bits 7:0.

The controller is a single state machine with these states:
- `S_IDLE`: waits for a start pulse.
- `S_RD_ENTRY` / `S_CAP_ENTRY`: issues the entry-point read, then captures the word.
- `S_RD_CNT` / `S_CAP_CNT`: issues the count read, then captures it and decides what comes next.
- `S_RD_DST` / `S_CAP_DST`: issues the destination-address read, then captures it.
- `S_RD_BYTE` / `S_WR_BYTE`: reads one payload byte, then writes it to the destination.
- `S_FINISH`: issues the entry-point strobe.
- `S_FAULT`: ends the load with an error.

Transitions:
- `S_IDLE` to `S_RD_ENTRY` when start is accepted.
- Each read state moves to its capture state.
- `S_CAP_ENTRY` to `S_RD_CNT`.
- `S_CAP_CNT` to `S_FINISH` when the count is zero.
- `S_CAP_CNT` to `S_FAULT` when the section limit is already used up.
- `S_CAP_CNT` to `S_RD_DST` in all other cases.
- `S_CAP_DST` to `S_RD_BYTE`.
- `S_WR_BYTE` back to `S_RD_BYTE` while bytes remain.
- `S_WR_BYTE` to `S_RD_CNT` after the last byte, with the source pointer realigned.
- `S_FINISH` and `S_FAULT` both return to `S_IDLE`.

Top module: `section_loader`

## Requirements
- R1: After reset, busy_o, done_o, error_o, entry_valid_o, src_rd_o and dst_we_o are all 0.
- R2: A start_i pulse seen in idle sets busy_o in the following cycle. In that same cycle the first source access is a word read (src_word_o=1) at table_base_i.
- R3: Header words are read as 32-bit little-endian words at 4-byte-aligned addresses. The first word is the entry point. Each section record is a count word followed by a destination-address word.
- R4: A section's payload of N bytes, starting right after its header, is written to destination addresses dst, dst+1, … dst+N-1 in source order. Exactly N writes are made, and a source read and a destination write never occur in the same cycle.
- R5: A count word of 0 ends the load. entry_valid_o is then high for exactly one cycle, with entry_o equal to the entry-point word.
- R6: When a payload ends at a source address that is not a multiple of 4, the next count word is read at the next multiple of 4.
- R7: A start_i pulse while busy_o is 1 is ignored. The running load completes with its own table and entry point.
- R8: If a table holds more than MAX_SECT non-empty sections, the load stops when the next count is read. It raises error_o and done_o, and never asserts entry_valid_o. Exactly MAX_SECT sections are accepted.
- R9: busy_o falls in the cycle after the strobe or the fault, when done_o rises. done_o and error_o hold until the next accepted start, which clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| table_base_i | input | AW | Byte address of the table (4-byte aligned) |
| src_rd_o | output | 1 | Source read request |
| src_word_o | output | 1 | 1 = 32-bit word read, 0 = byte read |
| src_addr_o | output | AW | Source byte address |
| src_rdata_i | input | 32 | Read data, one cycle after the request |
| dst_we_o | output | 1 | Destination byte write enable |
| dst_addr_o | output | AW | Destination byte address |
| dst_data_o | output | 8 | Destination write data |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | Load ended (held until next start) |
| error_o | output | 1 | Section limit exceeded (held until next start) |
| entry_o | output | 32 | Entry point read from the table |
| entry_valid_o | output | 1 | One-cycle strobe marking entry_o valid |

## Verification
The checks assume that table_base_i is a multiple of 4. Given that, every header read falls on an aligned address, and the source memory answers exactly one cycle after each request. The bench places every table at an aligned base and models the source memory with that fixed one-cycle latency. Section lengths, destinations and entry words are drawn at random, and the padding bytes between sections are filled with random garbage, so a wrong realignment shows up as a corrupted header. Directed cases add an empty table, an attempt to restart mid-load, a table exactly at the section limit and one just over it.

// File: rtl/loader_pkg.sv
package loader_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_RD_ENTRY,
        S_CAP_ENTRY,
        S_RD_CNT,
        S_CAP_CNT,
        S_RD_DST,
        S_CAP_DST,
        S_RD_BYTE,
        S_WR_BYTE,
        S_FINISH,
        S_FAULT
    } ldr_state_e;
endpackage

// File: rtl/ldr_src_ptr.sv
// Source pointer: load, word step, byte step, round up to 4-byte boundary.
module ldr_src_ptr #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] base_i,
    input  logic          step_word_i,
    input  logic          step_byte_i,
    input  logic          align_i,
    output logic [AW-1:0] ptr_o
);
    localparam logic [AW-1:0] ALIGN_MASK = ~AW'(3);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           ptr_o <= '0;
        else if (load_i)      ptr_o <= base_i;
        else if (step_word_i) ptr_o <= ptr_o + AW'(4);
        else if (step_byte_i) ptr_o <= ptr_o + AW'(1);
        else if (align_i)     ptr_o <= (ptr_o + AW'(3)) & ALIGN_MASK;
    end
endmodule

// File: rtl/ldr_sec_guard.sv
// Counts accepted sections and flags when the limit is used up.
module ldr_sec_guard #(
    parameter int MAX_SECT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic full_o
);
    localparam int CW = $clog2(MAX_SECT + 1);

    logic [CW-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      count_q <= '0;
        else if (clr_i)  count_q <= '0;
        else if (inc_i)  count_q <= count_q + CW'(1);
    end

    assign full_o = (count_q == CW'(MAX_SECT));
endmodule

// File: rtl/section_loader.sv
module section_loader
    import loader_pkg::*;
#(
    parameter int AW       = 32,
    parameter int MAX_SECT = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] table_base_i,
    output logic          src_rd_o,
    output logic          src_word_o,
    output logic [AW-1:0] src_addr_o,
    input  logic [31:0]   src_rdata_i,
    output logic          dst_we_o,
    output logic [AW-1:0] dst_addr_o,
    output logic [7:0]    dst_data_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          error_o,
    output logic [31:0]   entry_o,
    output logic          entry_valid_o
);
    ldr_state_e state_q, state_d;

    logic [31:0]   entry_q, cnt_q;
    logic [AW-1:0] dst_q;
    logic          done_q, err_q;

    logic ptr_load, ptr_word, ptr_byte, ptr_align;
    logic g_clr, g_inc, g_full;
    logic cap_entry, cap_cnt, cap_dst, wr_byte;
    logic set_done, set_err;
    logic [AW-1:0] ptr;

    ldr_src_ptr #(.AW(AW)) u_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (ptr_load),
        .base_i      (table_base_i),
        .step_word_i (ptr_word),
        .step_byte_i (ptr_byte),
        .align_i     (ptr_align),
        .ptr_o       (ptr)
    );

    ldr_sec_guard #(.MAX_SECT(MAX_SECT)) u_guard (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (g_clr),
        .inc_i  (g_inc),
        .full_o (g_full)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state and controls
    always_comb begin
        state_d       = state_q;
        src_rd_o      = 1'b0;
        src_word_o    = 1'b0;
        dst_we_o      = 1'b0;
        entry_valid_o = 1'b0;
        ptr_load      = 1'b0;
        ptr_word      = 1'b0;
        ptr_byte      = 1'b0;
        ptr_align     = 1'b0;
        g_clr         = 1'b0;
        g_inc         = 1'b0;
        cap_entry     = 1'b0;
        cap_cnt       = 1'b0;
        cap_dst       = 1'b0;
        wr_byte       = 1'b0;
        set_done      = 1'b0;
        set_err       = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) begin
                    ptr_load = 1'b1;
                    g_clr    = 1'b1;
                    state_d  = S_RD_ENTRY;
                end
            end
            S_RD_ENTRY: begin
                src_rd_o   = 1'b1;
                src_word_o = 1'b1;
                ptr_word   = 1'b1;
                state_d    = S_CAP_ENTRY;
            end
            S_CAP_ENTRY: begin
                cap_entry = 1'b1;
                state_d   = S_RD_CNT;
            end
            S_RD_CNT: begin
                src_rd_o   = 1'b1;
                src_word_o = 1'b1;
                ptr_word   = 1'b1;
                state_d    = S_CAP_CNT;
            end
            S_CAP_CNT: begin
                cap_cnt = 1'b1;
                if (src_rdata_i == 32'd0) begin
                    state_d = S_FINISH;
                end else if (g_full) begin
                    state_d = S_FAULT;
                end else begin
                    g_inc   = 1'b1;
                    state_d = S_RD_DST;
                end
            end
            S_RD_DST: begin
                src_rd_o   = 1'b1;
                src_word_o = 1'b1;
                ptr_word   = 1'b1;
                state_d    = S_CAP_DST;
            end
            S_CAP_DST: begin
                cap_dst = 1'b1;
                state_d = S_RD_BYTE;
            end
            S_RD_BYTE: begin
                src_rd_o = 1'b1;
                ptr_byte = 1'b1;
                state_d  = S_WR_BYTE;
            end
            S_WR_BYTE: begin
                dst_we_o = 1'b1;
                wr_byte  = 1'b1;
                if (cnt_q == 32'd1) begin
                    ptr_align = 1'b1;
                    state_d   = S_RD_CNT;
                end else begin
                    state_d   = S_RD_BYTE;
                end
            end
            S_FINISH: begin
                entry_valid_o = 1'b1;
                set_done      = 1'b1;
                state_d       = S_IDLE;
            end
            S_FAULT: begin
                set_done = 1'b1;
                set_err  = 1'b1;
                state_d  = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            entry_q <= '0;
            cnt_q   <= '0;
            dst_q   <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            if (cap_entry) entry_q <= src_rdata_i;
            if (cap_cnt)   cnt_q   <= src_rdata_i;
            else if (wr_byte) cnt_q <= cnt_q - 32'd1;
            if (cap_dst)   dst_q   <= src_rdata_i[AW-1:0];
            else if (wr_byte) dst_q <= dst_q + AW'(1);
            if (ptr_load) begin
                done_q <= 1'b0;
                err_q  <= 1'b0;
            end else begin
                if (set_done) done_q <= 1'b1;
                if (set_err)  err_q  <= 1'b1;
            end
        end
    end

    assign src_addr_o = ptr;
    assign dst_addr_o = dst_q;
    assign dst_data_o = src_rdata_i[7:0];
    assign busy_o     = (state_q != S_IDLE);
    assign done_o     = done_q;
    assign error_o    = err_q;
    assign entry_o    = entry_q;
endmodule

// File: rtl/section_loader_chk.sv
module section_loader_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          src_rd_o,
    input logic          src_word_o,
    input logic [AW-1:0] src_addr_o,
    input logic          dst_we_o,
    input logic          busy_o,
    input logic          done_o,
    input logic          error_o,
    input logic          entry_valid_o
);
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!src_rd_o && !dst_we_o && !entry_valid_o));

    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    p_word_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (src_rd_o && src_word_o) |-> (src_addr_o[1:0] == 2'b00));

    p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(src_rd_o && dst_we_o));

    p_strobe_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        entry_valid_o |=> !entry_valid_o);

    p_fault_no_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |-> !entry_valid_o);

    p_end_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        entry_valid_o |=> (done_o && !busy_o && !error_o));

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !done_o);
endmodule

bind section_loader section_loader_chk #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .src_rd_o      (src_rd_o),
    .src_word_o    (src_word_o),
    .src_addr_o    (src_addr_o),
    .dst_we_o      (dst_we_o),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .error_o       (error_o),
    .entry_valid_o (entry_valid_o)
);

// File: tb/tb_section_loader.sv
module tb_section_loader;
    localparam int AW   = 32;
    localparam int MAXS = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start_i;
    logic [AW-1:0] table_base_i;
    logic          src_rd_o, src_word_o;
    logic [AW-1:0] src_addr_o;
    logic [31:0]   src_rdata_i;
    logic          dst_we_o;
    logic [AW-1:0] dst_addr_o;
    logic [7:0]    dst_data_o;
    logic          busy_o, done_o, error_o, entry_valid_o;
    logic [31:0]   entry_o;

    always #10 clk = ~clk;

    section_loader #(.AW(AW), .MAX_SECT(MAXS)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .table_base_i(table_base_i),
        .src_rd_o(src_rd_o), .src_word_o(src_word_o), .src_addr_o(src_addr_o),
        .src_rdata_i(src_rdata_i), .dst_we_o(dst_we_o), .dst_addr_o(dst_addr_o),
        .dst_data_o(dst_data_o), .busy_o(busy_o), .done_o(done_o), .error_o(error_o),
        .entry_o(entry_o), .entry_valid_o(entry_valid_o)
    );

    logic [7:0] src_mem [0:4095];
    logic [7:0] dst_mem [0:4095];
    logic [7:0] exp_mem [0:4095];

    // Source memory: one-cycle latency, little-endian words
    always @(posedge clk) begin
        if (src_rd_o) begin
            if (src_word_o)
                src_rdata_i <= {src_mem[src_addr_o[11:0] + 12'd3], src_mem[src_addr_o[11:0] + 12'd2],
                                src_mem[src_addr_o[11:0] + 12'd1], src_mem[src_addr_o[11:0]]};
            else
                src_rdata_i <= {24'h0, src_mem[src_addr_o[11:0]]};
        end
        if (dst_we_o) dst_mem[dst_addr_o[11:0]] <= dst_data_o;
    end

    int n_chk = 0, n_bad = 0;
    int strobes = 0, writes = 0, cycles = 0;
    logic [31:0] strobe_val;

    always @(negedge clk) begin
        cycles++;
        if (entry_valid_o) begin
            strobes++;
            strobe_val = entry_o;
        end
        if (dst_we_o) writes++;
        if (cycles > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: act=%0d cycles exp<=150000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic put_word(input int a, input logic [31:0] w);
        for (int i = 0; i < 4; i++) src_mem[(a + i) & 12'hFFF] = w[8*i +: 8];
    endtask

    task automatic clear_dst();
        for (int i = 0; i < 4096; i++) begin
            dst_mem[i] = 8'h00;
            exp_mem[i] = 8'h00;
        end
    endtask

    int exp_bytes;

    // Builds a table of nsec sections (lengths 1..maxlen, or fixed when fixlen>0)
    task automatic build(input int base, input logic [31:0] entry, input int nsec,
                         input int maxlen, input int fixlen);
        int p;
        p = base;
        exp_bytes = 0;
        put_word(p, entry);
        p += 4;
        for (int s = 0; s < nsec; s++) begin
            int len, dst;
            len = (fixlen > 0) ? fixlen : $urandom_range(maxlen, 1);
            dst = $urandom_range(32'hF00, 0);
            put_word(p, len);
            put_word(p + 4, dst);
            p += 8;
            for (int i = 0; i < len; i++) begin
                logic [7:0] b;
                b = 8'($urandom);
                src_mem[p & 12'hFFF] = b;
                exp_mem[(dst + i) & 12'hFFF] = b;
                p++;
            end
            exp_bytes += len;
            p = (p + 3) & ~3;
        end
        put_word(p, 32'd0);
    endtask

    // Runs one load; inject_base>=0 adds a start pulse mid-load
    task automatic run(input int base, input int inject_base);
        int t;
        strobes = 0;
        writes  = 0;
        @(negedge clk);
        table_base_i = AW'(base);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o === 1'b1, "R2 busy after start", 32'(busy_o), 32'd1);
        check(src_rd_o && src_word_o && src_addr_o == AW'(base), "R2 first word read at base",
              src_addr_o, AW'(base));
        check(done_o === 1'b0 && error_o === 1'b0, "R9 flags cleared by start",
              {30'd0, done_o, error_o}, 32'd0);
        if (inject_base >= 0) begin
            repeat (3) @(negedge clk);
            table_base_i = AW'(inject_base);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        t = 0;
        while (!done_o && t < 20000) begin
            @(negedge clk);
            t++;
        end
        check(done_o === 1'b1, "R9 load ends", 32'(done_o), 32'd1);
        check(busy_o === 1'b0, "R9 busy low at end", 32'(busy_o), 32'd0);
    endtask

    task automatic compare_dst(input string req);
        int bad;
        bad = 0;
        for (int i = 0; i < 4096; i++) if (dst_mem[i] !== exp_mem[i]) bad++;
        check(bad == 0, req, bad, 0);
        check(writes == exp_bytes, "R4 write count", writes, exp_bytes);
    endtask

    task automatic good_run(input int base, input logic [31:0] entry, input int nsec,
                            input int maxlen, input int fixlen, input string req);
        clear_dst();
        build(base, entry, nsec, maxlen, fixlen);
        run(base, -1);
        compare_dst(req);
        check(strobes == 1, "R5 single strobe", strobes, 1);
        check(strobe_val == entry, "R5 entry value", strobe_val, entry);
        check(error_o === 1'b0, "R8 no error", 32'(error_o), 32'd0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4096; i++) src_mem[i] = 8'($urandom);
        rst_n = 1'b0;
        start_i = 1'b0;
        table_base_i = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check({busy_o, done_o, error_o, entry_valid_o, src_rd_o, dst_we_o} == 6'd0,
              "R1 reset outputs", {busy_o, done_o, error_o, entry_valid_o, src_rd_o, dst_we_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3 R4 R6: directed odd lengths forcing realignment
        good_run(32'h100, 32'h8000_1234, 2, 0, 5, "R6 odd-length sections realigned");
        good_run(32'h200, 32'hCAFE_0000, 3, 0, 1, "R6 one-byte sections");
        good_run(32'h300, 32'h0000_0400, 2, 0, 8, "R3 aligned-length sections");

        // R5: empty table
        good_run(32'h400, 32'h1357_9BDF, 0, 0, 1, "R5 empty table");
        repeat (5) @(negedge clk);
        check(done_o === 1'b1 && busy_o === 1'b0, "R5 done held after end",
              {30'd0, done_o, busy_o}, 32'd2);

        // R8: exactly MAXS sections accepted
        good_run(32'h500, 32'hA5A5_0001, MAXS, 7, 0, "R8 limit-sized table");

        // R8: one section too many
        clear_dst();
        build(32'h600, 32'h7777_7777, MAXS + 1, 0, 3);
        run(32'h600, -1);
        check(error_o === 1'b1, "R8 error flag", 32'(error_o), 32'd1);
        check(strobes == 0, "R8 no strobe on fault", strobes, 0);
        check(writes == 3 * MAXS, "R8 writes before fault", writes, 3 * MAXS);

        // R9: next start clears error
        good_run(32'h700, 32'h0BAD_F00D, 1, 4, 0, "R9 recovery after fault");

        // R7: start while busy ignored
        clear_dst();
        build(32'h800, 32'h2222_2222, 1, 0, 6);
        clear_dst();
        build(32'h040, 32'h1111_1111, 3, 0, 5);
        run(32'h040, 32'h800);
        compare_dst("R7 busy start ignored, data");
        check(strobe_val == 32'h1111_1111, "R7 entry of first table", strobe_val, 32'h1111_1111);

        // R4 R6: random tables
        for (int k = 0; k < 25; k++) begin
            int b;
            b = $urandom_range(32'h900, 0) & ~3;
            good_run(b, $urandom, $urandom_range(MAXS, 0), 11, 0, "R4 random table copy");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule